// File: doc/BRIEF.md
# Paged serial configuration register bank

This block is a serial configuration slave with a 4-wire interface: chip select (active low), serial clock, data in and data out. It gives a host access to a register space that is wider than its 5-bit address. The space is split into pages of 32 byte addresses. Address 0x1F is the page selector on every page, and the other addresses map onto the page that the selector currently names. To reach a register on another page, the host first writes that page number to 0x1F, then accesses the register.

The control registers on every page drive a flat parallel bus that the datapath consumes. A small set of addresses on each page reflects read-only status inputs. Bit 7 of control register 0 on page 0 switches the block to 3-wire operation. In that mode a single bidirectional pad carries both the command and the read data. The serial lines are oversampled in the system clock domain, so every register lives in that domain.

Top module: `cfg_spi_regfile`

## Requirements
- R1: After reset the page selector is 0 and every control register holds its reset value. With the default parameters that is 0x80 at page 1 address 1, 0x40 at page 1 address 2, and 0x00 elsewhere. The serial outputs are low and the pad enable is off.
- R2: A frame is 16 bits, sent MSB first and sampled on rising serial clock edges. Bit 15 is the direction (0 = write). Bits 14:13 are reserved and have no effect. Bits 12:8 are the address and bits 7:0 are the data. A write updates the addressed control register of the selected page once the 16th bit arrives.
- R3: When bit 15 is 1 the frame is a read. Data is driven MSB first. The first bit is launched on the falling edge after the 8th rising edge, so the host captures bits 7..0 on rising edges 9 to 16.
- R4: Address 0x1F reads and writes the page selector from any page. Only the low log2(pages) data bits are stored, so writing 0x0B with 8 pages selects page 3. A read returns the selector zero-extended.
- R5: The same address on different pages names distinct registers. A write on one page leaves the others unchanged.
- R6: On each page, addresses CTRL_REGS..CTRL_REGS+STAT_REGS-1 (4 and 5 by default) read the status inputs of that page. Writes to them change nothing.
- R7: Addresses that are neither control, status nor 0x1F read as 0x00. Writes to them change nothing.
- R8: If chip select rises before the 16th bit, the frame is aborted and no register or page selector changes.
- R9: With page 0 address 0 bit 7 set, read data appears on the pad output and the pad enable is high during the data phase, while the 4-wire data output stays low. With the bit clear, read data leaves on the 4-wire data output and the pad enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data in (the shared pad in 3-wire mode) |
| status_i | input | NUM_PAGES*STAT_REGS*8 | Read-only status bytes, entry page*STAT_REGS+index |
| spi_miso | output | 1 | 4-wire serial read data |
| spi_sdio_o | output | 1 | Pad output value for 3-wire reads |
| spi_sdio_oe | output | 1 | Pad drive enable for 3-wire reads |
| ctrl_o | output | NUM_PAGES*CTRL_REGS*8 | Control register contents, entry page*CTRL_REGS+address |
| page_o | output | log2(NUM_PAGES) | Current page selector |

## Verification
The bench builds the block with 8 pages, 4 control and 2 status registers per page, and two synchronizer stages. With these values the selector is 3 bits wide, so writing 0x0B shows the truncation to page 3. Addresses 6 to 0x1E exercise the unimplemented range. The serial clock half period is 8 system clocks, well beyond the synchronizer plus edge-detect latency. This lets the bench count edges exactly when it samples read data and when it aborts frames at 12 and 15 bits.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

   localparam int FRAME_BITS = 16;
   localparam int HDR_BITS   = 8;
   localparam int ADDR_W     = 5;
   localparam int DATA_W     = 8;
   localparam int MODE_BIT   = 7;

   localparam logic [ADDR_W-1:0] PAGE_SEL_ADDR = 5'h1F;

   // default reset image for 8 pages x 4 control registers
   localparam logic [255:0] DEF_CTRL_RST = 256'h0040_8000_0000_0000;

endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
   parameter int                WIDTH   = 3,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame
   import cfg_spi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr_q,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wr_data,
   output logic              dout,
   output logic              drive
);

   localparam int CNT_W = $clog2(FRAME_BITS + 1);
   localparam int BIT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] CNT_HDRL = CNT_W'(HDR_BITS - 1);
   localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS);

   logic              sclk_d;
   logic [CNT_W-1:0]  cnt;
   logic [HDR_BITS-2:0] shreg;
   logic              rd_q;
   logic [DATA_W-1:0] rd_lat;
   logic [CNT_W-1:0]  rev;
   logic              rise, fall;

   assign rise = ~cs_n & sclk & ~sclk_d;
   assign fall = ~cs_n & ~sclk & sclk_d;
   assign rev  = CNT_LAST - cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         cnt     <= '0;
         shreg   <= '0;
         rd_q    <= 1'b0;
         addr_q  <= '0;
         wr_stb  <= 1'b0;
         wr_data <= '0;
         rd_lat  <= '0;
         dout    <= 1'b0;
         drive   <= 1'b0;
      end else begin
         sclk_d <= sclk;
         wr_stb <= 1'b0;
         if (cs_n) begin
            cnt   <= '0;
            rd_q  <= 1'b0;
            dout  <= 1'b0;
            drive <= 1'b0;
         end else begin
            if (rise && cnt != CNT_FULL) begin
               shreg <= {shreg[HDR_BITS-3:0], sdi};
               cnt   <= cnt + 1'b1;
               if (cnt == CNT_HDRL) begin
                  rd_q   <= shreg[HDR_BITS-2];
                  addr_q <= {shreg[ADDR_W-2:0], sdi};
               end
               if (cnt == CNT_LAST && !rd_q) begin
                  wr_stb  <= 1'b1;
                  wr_data <= {shreg, sdi};
               end
            end
            if (fall && rd_q && cnt >= CNT_HDR && cnt < CNT_FULL) begin
               if (cnt == CNT_HDR) begin
                  rd_lat <= rd_data;
                  dout   <= rd_data[DATA_W-1];
                  drive  <= 1'b1;
               end else begin
                  dout <= rd_lat[rev[BIT_W-1:0]];
               end
            end
         end
      end
   end

endmodule

// File: rtl/cfg_spi_bank.sv
module cfg_spi_bank
   import cfg_spi_pkg::*;
#(
   parameter int NUM_PAGES = 8,
   parameter int CTRL_REGS = 4,
   parameter int STAT_REGS = 2,
   parameter logic [NUM_PAGES*CTRL_REGS*8-1:0] CTRL_RST = '0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_stb,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic [NUM_PAGES*STAT_REGS*8-1:0]  status_i,
   output logic [DATA_W-1:0]                 rd_data,
   output logic [NUM_PAGES*CTRL_REGS*8-1:0]  ctrl_o,
   output logic [$clog2(NUM_PAGES)-1:0]      page_o
);

   localparam int PAGE_W = $clog2(NUM_PAGES);
   localparam int NREGS  = NUM_PAGES * CTRL_REGS;

   logic [PAGE_W-1:0] page_q;
   logic [DATA_W-1:0] regs [NREGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (wr_stb && addr == PAGE_SEL_ADDR) begin
         page_q <= wr_data[PAGE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NREGS; k++) regs[k] <= CTRL_RST[k*8 +: 8];
      end else if (wr_stb) begin
         for (int p = 0; p < NUM_PAGES; p++) begin
            for (int r = 0; r < CTRL_REGS; r++) begin
               if (page_q == PAGE_W'(p) && addr == ADDR_W'(r))
                  regs[p*CTRL_REGS+r] <= wr_data;
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (addr == PAGE_SEL_ADDR) begin
         rd_data[PAGE_W-1:0] = page_q;
      end
      for (int p = 0; p < NUM_PAGES; p++) begin
         for (int r = 0; r < CTRL_REGS; r++) begin
            if (page_q == PAGE_W'(p) && addr == ADDR_W'(r))
               rd_data = regs[p*CTRL_REGS+r];
         end
         for (int s = 0; s < STAT_REGS; s++) begin
            if (page_q == PAGE_W'(p) && addr == ADDR_W'(CTRL_REGS + s))
               rd_data = status_i[(p*STAT_REGS+s)*8 +: 8];
         end
      end
   end

   for (genvar k = 0; k < NREGS; k++) begin : g_pack
      assign ctrl_o[k*8 +: 8] = regs[k];
   end

   assign page_o = page_q;

endmodule

// File: rtl/cfg_spi_regfile.sv
module cfg_spi_regfile
   import cfg_spi_pkg::*;
#(
   parameter int NUM_PAGES   = 8,
   parameter int CTRL_REGS   = 4,
   parameter int STAT_REGS   = 2,
   parameter int SYNC_STAGES = 2,
   parameter logic [NUM_PAGES*CTRL_REGS*8-1:0] CTRL_RST = DEF_CTRL_RST
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              spi_sclk,
   input  logic                              spi_cs_n,
   input  logic                              spi_sdi,
   input  logic [NUM_PAGES*STAT_REGS*8-1:0]  status_i,
   output logic                              spi_miso,
   output logic                              spi_sdio_o,
   output logic                              spi_sdio_oe,
   output logic [NUM_PAGES*CTRL_REGS*8-1:0]  ctrl_o,
   output logic [$clog2(NUM_PAGES)-1:0]      page_o
);

   localparam int PAGE_W = $clog2(NUM_PAGES);

   if (NUM_PAGES < 2 || NUM_PAGES > 256 || (1 << PAGE_W) != NUM_PAGES) begin : g_bad_pages
      $error("NUM_PAGES must be a power of two from 2 to 256");
   end
   if (CTRL_REGS < 1 || STAT_REGS < 1 || CTRL_REGS + STAT_REGS > 31) begin : g_bad_regs
      $error("CTRL_REGS and STAT_REGS must fit below the page selector address");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              sclk_s, cs_s, sdi_s;
   logic [ADDR_W-1:0] fr_addr;
   logic              wr_stb;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;
   logic              dout, drive;
   logic              mode_3w;

   cfg_spi_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_sclk, spi_cs_n, spi_sdi}),
      .q     ({sclk_s, cs_s, sdi_s})
   );

   cfg_spi_frame u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk    (sclk_s),
      .cs_n    (cs_s),
      .sdi     (sdi_s),
      .rd_data (rd_data),
      .addr_q  (fr_addr),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .dout    (dout),
      .drive   (drive)
   );

   cfg_spi_bank #(
      .NUM_PAGES (NUM_PAGES),
      .CTRL_REGS (CTRL_REGS),
      .STAT_REGS (STAT_REGS),
      .CTRL_RST  (CTRL_RST)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .addr     (fr_addr),
      .wr_data  (wr_data),
      .status_i (status_i),
      .rd_data  (rd_data),
      .ctrl_o   (ctrl_o),
      .page_o   (page_o)
   );

   assign mode_3w     = ctrl_o[MODE_BIT];
   assign spi_miso    = ~mode_3w & drive & dout;
   assign spi_sdio_o  =  mode_3w & drive & dout;
   assign spi_sdio_oe =  mode_3w & drive;

endmodule

// File: rtl/cfg_spi_regfile_chk.sv
module cfg_spi_regfile_chk #(
   parameter int CTRL_W = 256,
   parameter int PAGE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_s,
   input logic              wr_stb,
   input logic [4:0]        wr_addr,
   input logic [CTRL_W-1:0] ctrl_o,
   input logic [PAGE_W-1:0] page_o,
   input logic              spi_miso,
   input logic              spi_sdio_oe
);

   // R2: control outputs move only one cycle after a completed write frame
   a_r2_ctrl_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_o) |-> $past(wr_stb));

   // R4: the page selector moves only after a write to the selector address
   a_r4_page_needs_sel_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(page_o) |-> $past(wr_stb && wr_addr == 5'h1F));

   // R8: no commit is issued while the synchronized chip select is high
   a_r8_no_commit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !cs_s);

   // R3: read drivers release once the frame has ended
   a_r3_release_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (!spi_miso && !spi_sdio_oe));

endmodule

bind cfg_spi_regfile cfg_spi_regfile_chk #(
   .CTRL_W (NUM_PAGES*CTRL_REGS*8),
   .PAGE_W ($clog2(NUM_PAGES))
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_s        (cs_s),
   .wr_stb      (wr_stb),
   .wr_addr     (fr_addr),
   .ctrl_o      (ctrl_o),
   .page_o      (page_o),
   .spi_miso    (spi_miso),
   .spi_sdio_oe (spi_sdio_oe)
);

// File: tb/cfg_spi_regfile_bench.sv
module cfg_spi_regfile_bench;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int NP         = 8;
   localparam int CR         = 4;
   localparam int SR         = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic mst_sdi = 1'b0;
   logic [NP*SR*8-1:0] status = '0;
   logic miso, sdio_o, sdio_oe;
   logic [NP*CR*8-1:0] ctrl;
   logic [2:0] page;
   logic sdi_pin;

   int n_run = 0;
   int n_fail = 0;

   assign sdi_pin = sdio_oe ? sdio_o : mst_sdi;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_spi_regfile u_cfg_spi_regfile (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_sclk    (sclk),
      .spi_cs_n    (cs_n),
      .spi_sdi     (sdi_pin),
      .status_i    (status),
      .spi_miso    (miso),
      .spi_sdio_o  (sdio_o),
      .spi_sdio_oe (sdio_oe),
      .ctrl_o      (ctrl),
      .page_o      (page)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic int creg(input int p, input int r);
      return int'(ctrl[(p*CR+r)*8 +: 8]);
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input bit rd, input bit [1:0] rsv, input bit [4:0] a,
                       input bit [7:0] d, input int nbits,
                       output bit [7:0] q, output bit miso_hit, output bit oe_all);
      logic [15:0] f;
      f = {rd, rsv, a, d};
      q = '0;
      miso_hit = 1'b0;
      oe_all = 1'b1;
      cs_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < nbits; i++) begin
         mst_sdi = f[15-i];
         wait_clk(HALF);
         if (i >= 8) begin
            q[15-i] = sdio_oe ? sdio_o : miso;
            if (miso) miso_hit = 1'b1;
            if (!sdio_oe) oe_all = 1'b0;
         end
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
      end
      wait_clk(HALF);
      cs_n = 1'b1;
      mst_sdi = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic wr(input bit [4:0] a, input bit [7:0] d);
      bit [7:0] q; bit mh, oa;
      xfer(1'b0, 2'b00, a, d, 16, q, mh, oa);
   endtask

   task automatic rd(input bit [4:0] a, output bit [7:0] q);
      bit mh, oa;
      xfer(1'b1, 2'b00, a, 8'h00, 16, q, mh, oa);
   endtask

   task automatic t_reset();
      bit [7:0] q;
      chk("R1", "page after reset", int'(page), 0);
      chk("R1", "page1 addr1 reset", creg(1, 1), 'h80);
      chk("R1", "page1 addr2 reset", creg(1, 2), 'h40);
      chk("R1", "page0 addr0 reset", creg(0, 0), 0);
      chk("R1", "miso idle", int'(miso), 0);
      chk("R1", "pad enable idle", int'(sdio_oe), 0);
      rd(5'h1F, q);
      chk("R1", "selector read after reset", int'(q), 0);
   endtask

   task automatic t_write_read();
      bit [7:0] q; bit mh, oa;
      wr(5'h01, 8'hA5);
      chk("R2", "page0 addr1 after write", creg(0, 1), 'hA5);
      rd(5'h01, q);
      chk("R3", "read back page0 addr1", int'(q), 'hA5);
      xfer(1'b0, 2'b11, 5'h03, 8'h3C, 16, q, mh, oa);
      chk("R2", "write with reserved bits set", creg(0, 3), 'h3C);
      xfer(1'b1, 2'b11, 5'h03, 8'h00, 16, q, mh, oa);
      chk("R3", "read with reserved bits set", int'(q), 'h3C);
      chk("R3", "4-wire read leaves pad disabled", int'(oa), 0);
   endtask

   task automatic t_paging();
      bit [7:0] q;
      wr(5'h1F, 8'h04);
      chk("R4", "page after selecting 4", int'(page), 4);
      wr(5'h02, 8'h77);
      chk("R5", "page4 addr2 written", creg(4, 2), 'h77);
      chk("R5", "page0 addr2 untouched", creg(0, 2), 0);
      rd(5'h02, q);
      chk("R5", "read page4 addr2", int'(q), 'h77);
      rd(5'h1F, q);
      chk("R4", "selector read from page 4", int'(q), 4);
      wr(5'h1F, 8'h0B);
      chk("R4", "selector keeps low bits", int'(page), 3);
      rd(5'h1F, q);
      chk("R4", "selector read zero-extended", int'(q), 3);
   endtask

   task automatic t_status();
      bit [7:0] q;
      logic [NP*CR*8-1:0] snap;
      status[(3*SR+0)*8 +: 8] = 8'h5A;
      status[(3*SR+1)*8 +: 8] = 8'hC3;
      rd(5'h04, q);
      chk("R6", "status page3 index0", int'(q), 'h5A);
      rd(5'h05, q);
      chk("R6", "status page3 index1", int'(q), 'hC3);
      snap = ctrl;
      wr(5'h04, 8'hFF);
      rd(5'h04, q);
      chk("R6", "status unchanged by write", int'(q), 'h5A);
      chk("R6", "control bus unchanged by status write", int'(ctrl == snap), 1);
   endtask

   task automatic t_unimpl();
      bit [7:0] q;
      logic [NP*CR*8-1:0] snap;
      rd(5'h10, q);
      chk("R7", "unimplemented read", int'(q), 0);
      snap = ctrl;
      wr(5'h1E, 8'hFF);
      chk("R7", "control bus unchanged", int'(ctrl == snap), 1);
      chk("R7", "page unchanged", int'(page), 3);
      rd(5'h1E, q);
      chk("R7", "unimplemented read after write", int'(q), 0);
   endtask

   task automatic t_abort();
      bit [7:0] q; bit mh, oa;
      xfer(1'b0, 2'b00, 5'h00, 8'h11, 15, q, mh, oa);
      chk("R8", "15-bit frame no update", creg(3, 0), 0);
      xfer(1'b0, 2'b00, 5'h1F, 8'h01, 12, q, mh, oa);
      chk("R8", "12-bit selector frame no update", int'(page), 3);
      wr(5'h00, 8'h11);
      chk("R8", "full frame after abort updates", creg(3, 0), 'h11);
   endtask

   task automatic t_three_wire();
      bit [7:0] q; bit mh, oa;
      wr(5'h1F, 8'h00);
      wr(5'h00, 8'h80);
      chk("R9", "3-wire mode bit set", creg(0, 0), 'h80);
      xfer(1'b1, 2'b00, 5'h01, 8'h00, 16, q, mh, oa);
      chk("R9", "3-wire read data on pad", int'(q), 'hA5);
      chk("R9", "4-wire output quiet in 3-wire", int'(mh), 0);
      chk("R9", "pad enabled during data phase", int'(oa), 1);
      wr(5'h00, 8'h00);
      chk("R9", "back to 4-wire", creg(0, 0), 0);
      xfer(1'b1, 2'b00, 5'h01, 8'h00, 16, q, mh, oa);
      chk("R9", "4-wire read data on output", int'(q), 'hA5);
      chk("R9", "pad disabled in 4-wire", int'(oa), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_write_read();
      t_paging();
      t_status();
      t_unimpl();
      t_abort();
      t_three_wire();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule